// File: doc/BRIEF.md
# Qualified Falling-Edge Capture Latches

This block watches two asynchronous, normally-high event pins and remembers, in one sticky flag per pin, that a pin went from high to low. A drop counts only if the pin then stays low for at least a set number of instruction cycles, two by default. Shorter glitches are ignored. Each pin is brought into the instruction-cycle clock domain by its own multi-flop synchroniser before any edge logic looks at it. A third input, a clock-monitor level, is synchronised the same way.

A consumer reads the block through a 4-bit nibble that is always present on the output. The flag of the upper pin sits in bit 3 and the flag of the lower pin in bit 0. Bit 2 is the synchronised clock-monitor level and bit 1 is tied to zero. Pulsing the read strobe for one cycle consumes the nibble shown in that cycle and clears both flags at the next clock edge. A capture that qualifies in that same cycle is not lost: it is kept and appears in the following read. The accumulator that receives the nibble and the instruction decode that produces the strobe sit outside this block.

Top module: `edgecap_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, both capture flags are cleared, and the nibble then reads 4'b0000 with the monitor input low.
- R2: A high-to-low transition on `ev_hi_i` that stays low for two sampled cycles sets nibble bit 3. The same on `ev_lo_i` sets nibble bit 0. The flag is visible four clock edges after the pin first goes low: two synchroniser stages, one qualification cycle and the flag register.
- R3: A low pulse that lasts only one instruction cycle sets no flag.
- R4: Nibble bit 2 equals the clock-monitor input delayed by the two-stage synchroniser, and nibble bit 1 is always 0.
- R5: A read (strobe high at a clock edge) clears both flags at that edge, so the next read shows 0 in bits 3 and 0 unless a new edge has qualified.
- R6: A capture that qualifies in the same cycle as a read wins over the clear. The read returns the old flag value, and the flag is set for the next read.
- R7: A flag stays set across any number of cycles without a read. An input held low captures only once per falling edge, so a read after the clear returns 0 while the pin stays low.
- R8: The two channels are independent: an edge on one pin never sets the other pin's flag, and both flags can be set together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_hi_i | input | 1 | Asynchronous event pin whose flag is nibble bit 3 |
| ev_lo_i | input | 1 | Asynchronous event pin whose flag is nibble bit 0 |
| clkmon_i | input | 1 | Asynchronous clock-monitor level, reported in nibble bit 2 |
| rd_en_i | input | 1 | One-cycle read strobe; clears both flags at the edge |
| rd_nibble_o | output | 4 | Read nibble {flag hi, monitor, 0, flag lo} |

## Verification
The hardest case to reach is a qualification that lands in exactly the cycle of a read. This needs the strobe placed on the one cycle in which the second low sample is seen behind the synchroniser. The bench counts edges from the moment it drops the pin: the pin goes low, it returns high after two edges, and the read is raised after the third edge. The read is then sampled before the fourth edge, where both set and clear act. A second read confirms that the capture survived. Glitch rejection is reached the same way, with a pin held low across exactly one sampling edge.

// File: rtl/edgecap_pkg.sv
package edgecap_pkg;

    // Width of the read nibble.
    localparam int NIB_W = 4;
    // Number of event channels in the block.
    localparam int NUM_CH = 2;
    // Nibble bit positions: fixed by the consumer that decodes the nibble.
    localparam int BIT_HI  = 3;
    localparam int BIT_MON = 2;
    localparam int BIT_ZERO = 1;
    localparam int BIT_LO  = 0;
    // Channel indices inside the flag vector.
    localparam int CH_LO = 0;
    localparam int CH_HI = 1;

    // Read nibble layout.
    typedef struct packed {
        logic hi_cap;
        logic mon;
        logic zero;
        logic lo_cap;
    } rd_nib_t;

endpackage

// File: rtl/edgecap_sync.sv
// edgecap_sync: multi-flop synchroniser for one asynchronous level.
// Assumes STAGES >= 2 and that the input is a slow level, not a bus.
// On reset the chain loads RST_VAL, the level the input idles at.
module edgecap_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/edgecap_qual.sv
// edgecap_qual: falling-edge qualifier for one synchronised level.
// It emits a one-cycle pulse when the level has been low for MIN_LOW
// consecutive cycles after a high. It assumes MIN_LOW >= 1. The level
// must be seen high once after reset before any capture can happen.
module edgecap_qual #(
    parameter int MIN_LOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic qual_o
);

    localparam int            CW       = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] RUN_MAX  = CW'(MIN_LOW);
    localparam logic [CW-1:0] RUN_LAST = CW'(MIN_LOW - 1);

    logic          armed_q;
    logic [CW-1:0] run_q;

    // Track whether a high was seen, and count the low cycles after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            run_q   <= '0;
        end else if (level_i) begin
            armed_q <= 1'b1;
            run_q   <= '0;
        end else if (armed_q && (run_q != RUN_MAX)) begin
            run_q <= run_q + 1'b1;
        end
    end

    // The pulse fires on the MIN_LOW-th consecutive low sample.
    assign qual_o = armed_q && !level_i && (run_q == RUN_LAST);

    // R7: a held-low level qualifies only once.
    p_one_shot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |=> !qual_o);

    generate
        if (MIN_LOW >= 2) begin : g_two_low
            // R3: a pulse needs at least two low samples in a row.
            p_two_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
                qual_o |-> (!level_i && !$past(level_i)));
        end
    endgenerate

endmodule

// File: rtl/edgecap_flag.sv
// edgecap_flag: sticky capture flag with clear-on-read.
// A set in the same cycle as a clear wins, so a coincident capture
// is kept for the next read.
module edgecap_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // Hold the capture until a read clears it; a set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

    // R6: a coincident set survives the read.
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R5: a read with no new capture clears the flag.
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    // R7: without a read the flag stays set.
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/edgecap_top.sv
// edgecap_top: two qualified falling-edge capture flags plus a
// synchronised clock-monitor level, read as one nibble.
// Assumes clk is the instruction-cycle clock and rd_en_i is a one-cycle
// strobe from the decode logic. The nibble is valid in every cycle.
module edgecap_top #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_hi_i,
    input  logic       ev_lo_i,
    input  logic       clkmon_i,
    input  logic       rd_en_i,
    output logic [3:0] rd_nibble_o
);
    import edgecap_pkg::*;

    logic [NUM_CH-1:0] pin_raw;
    logic [NUM_CH-1:0] pin_sync;
    logic [NUM_CH-1:0] qual;
    logic [NUM_CH-1:0] cap;
    logic              mon_sync;
    rd_nib_t           nib;

    assign pin_raw[CH_LO] = ev_lo_i;
    assign pin_raw[CH_HI] = ev_hi_i;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            edgecap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .async_i(pin_raw[ch]),
                .sync_o (pin_sync[ch])
            );
            edgecap_qual #(.MIN_LOW(MIN_LOW)) u_qual (
                .clk    (clk),
                .rst_n  (rst_n),
                .level_i(pin_sync[ch]),
                .qual_o (qual[ch])
            );
            edgecap_flag u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (qual[ch]),
                .clr_i (rd_en_i),
                .flag_o(cap[ch])
            );
        end
    endgenerate

    edgecap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mon_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(clkmon_i),
        .sync_o (mon_sync)
    );

    // Assemble the read nibble in its fixed bit order.
    always_comb begin
        nib.hi_cap = cap[CH_HI];
        nib.mon    = mon_sync;
        nib.zero   = 1'b0;
        nib.lo_cap = cap[CH_LO];
    end

    assign rd_nibble_o = nib;

    // R1: reset leaves both flags clear.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (cap == '0));
    // R8: a flag sets only when its own channel qualified.
    p_own_channel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap[CH_LO] && !qual[CH_LO]) |=> !cap[CH_LO]);

endmodule

// File: tb/tb_edgecap_top.sv
module tb_edgecap_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_hi = 1'b1;
    logic       ev_lo = 1'b1;
    logic       mon = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] nib;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    edgecap_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_hi_i    (ev_hi),
        .ev_lo_i    (ev_lo),
        .clkmon_i   (mon),
        .rd_en_i    (rd_en),
        .rd_nibble_o(nib)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    // Driver: queue the expected nibble, then pulse the read strobe.
    task automatic read_expect(input logic [3:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_en = 1'b1;
        step(1);
        rd_en = 1'b0;
    endtask

    // Monitor: compare the nibble away from the active edge during reads.
    always @(negedge clk) begin
        if (rd_en && rst_n) begin
            logic [3:0] e;
            string      t;
            if (exp_q.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL scoreboard: read with empty queue, got %b expected none", nib);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (nib !== e) begin
                    n_bad++;
                    $display("FAIL %s: got %b expected %b", t, nib, e);
                end
                n_chk++;
                if (nib[1] !== 1'b0) begin
                    n_bad++;
                    $display("FAIL R4 bit1: got %b expected 0", nib[1]);
                end
            end
        end
    end

    // Drop a pin for a given number of cycles, then raise it again.
    task automatic pulse(input bit hi, input bit lo, input int len);
        if (hi) ev_hi = 1'b0;
        if (lo) ev_lo = 1'b0;
        step(len);
        ev_hi = 1'b1;
        ev_lo = 1'b1;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(4);
        read_expect(4'b0000, "R1 after reset");

        pulse(1'b1, 1'b0, 2);
        step(5);
        read_expect(4'b1000, "R2 hi capture");
        read_expect(4'b0000, "R5 cleared by read");

        pulse(1'b0, 1'b1, 2);
        step(5);
        read_expect(4'b0001, "R2 lo capture (R8 only own bit)");

        pulse(1'b1, 1'b1, 1);
        step(6);
        read_expect(4'b0000, "R3 one-cycle glitch");

        mon = 1'b1;
        step(4);
        read_expect(4'b0100, "R4 monitor high");
        mon = 1'b0;
        step(4);
        read_expect(4'b0000, "R4 monitor low");

        ev_lo = 1'b0;
        step(6);
        read_expect(4'b0001, "R7 held low first read");
        step(4);
        read_expect(4'b0000, "R7 held low no recapture");
        ev_lo = 1'b1;
        step(3);

        pulse(1'b1, 1'b0, 2);
        step(20);
        read_expect(4'b1000, "R7 sticky");

        pulse(1'b1, 1'b1, 2);
        step(5);
        read_expect(4'b1001, "R8 both channels");
        read_expect(4'b0000, "R5 both cleared");

        // Coincident qualification and read.
        ev_hi = 1'b0;
        step(2);
        ev_hi = 1'b1;
        step(1);
        read_expect(4'b0000, "R6 read in qualify cycle");
        step(2);
        read_expect(4'b1000, "R6 capture kept");

        pulse(1'b0, 1'b1, 2);
        step(5);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(4);
        read_expect(4'b0000, "R1 reset clears flag");

        step(2);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule